// File: doc/BRIEF.md
# Serial Channel Modem Control Register with Diagnostic Loopback

This block holds the modem-control byte of one serial channel and the steering logic that byte drives. Software writes the byte over a simple register bus and reads it back. The low bits control the two active-low handshake outputs (data-terminal-ready and request-to-send). Another bit gates the channel's interrupt request onto the external interrupt pin. A spare bit is a general-purpose internal output.

One bit switches the channel into a local diagnostic loopback. In loopback the transmit shift register's serial output goes straight to the receive shift register's serial input, and the serial output pin idles at the marking level. The handshake outputs are parked inactive. The four modem-status lines seen by the channel are no longer taken from the pins. They are taken from the low four register bits, so that software can exercise the transmit, receive and status-change paths with no external wiring.

The shift registers, baud generation, FIFOs and interrupt prioritisation sit outside this block. It connects to them through the `tsr_sout`, `rsr_sin`, `irq_req` and true-sense status ports. Every output follows the register state with no added latency.

Top module: `modem_ctrl_unit`

## Requirements
- R1: After reset the register reads 0x00, `dtr_n_pin` and `rts_n_pin` are 1, `ser_out_pin` follows `tsr_sout`, and `irq_pin` is 0.
- R2: With loopback off (bit 4 = 0), register bit 0 drives `dtr_n_pin` inverted: a 1 gives a low pin and a 0 gives a high pin.
- R3: With loopback off, register bit 1 drives `rts_n_pin` inverted in the same way.
- R4: `irq_pin` equals `irq_req` when register bit 3 is 1 and is 0 when bit 3 is 0.
- R5: A write stores bits 4:0 of `reg_wdata`. Bits 7:5 always read 0, and writes to them are ignored. The register holds its value while `reg_we` is 0.
- R6: With bit 4 = 1, `ser_out_pin` is 1, `rsr_sin` equals `tsr_sout`, and `ser_in_pin` has no effect. With bit 4 = 0, `ser_out_pin` equals `tsr_sout` and `rsr_sin` equals `ser_in_pin`.
- R7: With bit 4 = 0, each status output is the inverse of its active-low pin. With bit 4 = 1 the pins are ignored, and the status outputs take these values: `st_dsr` = bit 0, `st_cts` = bit 1, `st_ri` = bit 2, `st_dcd` = bit 3.
- R8: With bit 4 = 1, `dtr_n_pin` and `rts_n_pin` are 1, whatever bits 0 and 1 hold.
- R9: With loopback off, bit 2 has no effect on any output other than the read data.
- R10: In loopback, bit 3 still gates `irq_pin`, and the status outputs change only when the register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ser_in_pin | input | 1 | External serial input |
| ser_out_pin | output | 1 | External serial output |
| tsr_sout | input | 1 | Serial output of the transmit shift register |
| rsr_sin | output | 1 | Serial input to the receive shift register |
| dtr_n_pin | output | 1 | Data-terminal-ready, active low |
| rts_n_pin | output | 1 | Request-to-send, active low |
| cts_n_pin | input | 1 | Clear-to-send, active low |
| dsr_n_pin | input | 1 | Data-set-ready, active low |
| dcd_n_pin | input | 1 | Carrier detect, active low |
| ri_n_pin | input | 1 | Ring indicator, active low |
| st_cts | output | 1 | Clear-to-send status, true sense |
| st_dsr | output | 1 | Data-set-ready status, true sense |
| st_dcd | output | 1 | Carrier-detect status, true sense |
| st_ri | output | 1 | Ring-indicator status, true sense |
| irq_req | input | 1 | Interrupt request from the channel's interrupt logic |
| irq_pin | output | 1 | External interrupt output |

## Verification
The vector table writes register values that set the handshake bits one at a time and together, with and without the interrupt enable and the loop bit. Each vector drives modem pin patterns that differ from the register's low nibble. This tells pin-sourced status apart from register-sourced status, and shows whether each status line has the right register bit behind it. Serial input and transmit output are set to opposite values, so the bench can see which source feeds the receive path. Directed tests toggle pins that loopback should ignore, flip the spare bit to show it has no external effect, write ones into the unused upper bits, and apply reset in the middle of a run.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // Control byte layout; bit positions are decoded by the steering logic.
    typedef struct packed {
        logic loop_en;   // bit 4
        logic irq_en;    // bit 3
        logic aux_out;   // bit 2
        logic rts_on;    // bit 1
        logic dtr_on;    // bit 0
    } mcr_ctrl_t;

    localparam int unsigned CTRL_W    = $bits(mcr_ctrl_t);
    localparam int unsigned NUM_LINES = 4;

    // Status line indices
    localparam int unsigned LN_CTS = 0;
    localparam int unsigned LN_DSR = 1;
    localparam int unsigned LN_DCD = 2;
    localparam int unsigned LN_RI  = 3;

    // Register bit that feeds each status line in loopback
    function automatic int unsigned loop_src(input int unsigned line);
        case (line)
            LN_CTS:  return 1;
            LN_DSR:  return 0;
            LN_DCD:  return 3;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/mcr_regfile.sv
module mcr_regfile
    import mcr_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output mcr_ctrl_t        ctrl
);
    localparam int unsigned PAD_W = REG_W - CTRL_W;

    typedef struct packed {
        mcr_ctrl_t ctrl;
    } state_t;

    state_t state_d, state_q;

    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[REG_W-1:CTRL_W];

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.ctrl = mcr_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl  = state_q.ctrl;
    assign rdata = {{PAD_W{1'b0}}, state_q.ctrl};

endmodule

// File: rtl/mcr_serial_steer.sv
module mcr_serial_steer (
    input  logic loop_en,
    input  logic tsr_sout,
    input  logic ser_in_pin,
    output logic ser_out_pin,
    output logic rsr_sin
);
    always_comb begin
        if (loop_en) begin
            ser_out_pin = 1'b1;       // marking level
            rsr_sin     = tsr_sout;
        end else begin
            ser_out_pin = tsr_sout;
            rsr_sin     = ser_in_pin;
        end
    end
endmodule

// File: rtl/mcr_modem_steer.sv
module mcr_modem_steer
    import mcr_pkg::*;
(
    input  mcr_ctrl_t             ctrl,
    input  logic                  irq_req,
    input  logic [NUM_LINES-1:0]  pins_n,
    output logic [NUM_LINES-1:0]  status,
    output logic                  dtr_n,
    output logic                  rts_n,
    output logic                  irq_out
);
    logic [NUM_LINES-1:0] low_bits;
    assign low_bits = {ctrl.irq_en, ctrl.aux_out, ctrl.rts_on, ctrl.dtr_on};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int unsigned SRC = loop_src(g);
        assign status[g] = ctrl.loop_en ? low_bits[SRC] : ~pins_n[g];
    end

    always_comb begin
        dtr_n   = ctrl.loop_en ? 1'b1 : ~ctrl.dtr_on;
        rts_n   = ctrl.loop_en ? 1'b1 : ~ctrl.rts_on;
        irq_out = irq_req & ctrl.irq_en;
    end
endmodule

// File: rtl/modem_ctrl_unit.sv
module modem_ctrl_unit
    import mcr_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ser_in_pin,
    output logic             ser_out_pin,
    input  logic             tsr_sout,
    output logic             rsr_sin,
    output logic             dtr_n_pin,
    output logic             rts_n_pin,
    input  logic             cts_n_pin,
    input  logic             dsr_n_pin,
    input  logic             dcd_n_pin,
    input  logic             ri_n_pin,
    output logic             st_cts,
    output logic             st_dsr,
    output logic             st_dcd,
    output logic             st_ri,
    input  logic             irq_req,
    output logic             irq_pin
);
    mcr_ctrl_t            ctrl;
    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] status;

    always_comb begin
        pins_n         = '0;
        pins_n[LN_CTS] = cts_n_pin;
        pins_n[LN_DSR] = dsr_n_pin;
        pins_n[LN_DCD] = dcd_n_pin;
        pins_n[LN_RI]  = ri_n_pin;
    end

    mcr_regfile #(.REG_W(REG_W)) i_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    mcr_serial_steer i_serial (
        .loop_en     (ctrl.loop_en),
        .tsr_sout    (tsr_sout),
        .ser_in_pin  (ser_in_pin),
        .ser_out_pin (ser_out_pin),
        .rsr_sin     (rsr_sin)
    );

    mcr_modem_steer i_modem (
        .ctrl    (ctrl),
        .irq_req (irq_req),
        .pins_n  (pins_n),
        .status  (status),
        .dtr_n   (dtr_n_pin),
        .rts_n   (rts_n_pin),
        .irq_out (irq_pin)
    );

    assign st_cts = status[LN_CTS];
    assign st_dsr = status[LN_DSR];
    assign st_dcd = status[LN_DCD];
    assign st_ri  = status[LN_RI];

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             ser_in_pin,
    input logic             ser_out_pin,
    input logic             tsr_sout,
    input logic             rsr_sin,
    input logic             dtr_n_pin,
    input logic             rts_n_pin,
    input logic             cts_n_pin,
    input logic             dsr_n_pin,
    input logic             dcd_n_pin,
    input logic             ri_n_pin,
    input logic             st_cts,
    input logic             st_dsr,
    input logic             st_dcd,
    input logic             st_ri,
    input logic             irq_req,
    input logic             irq_pin
);
    localparam logic [REG_W-1:0] KEEP_MASK = REG_W'(5'h1F);

    AST_DTR_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |-> (dtr_n_pin == !reg_rdata[0])); // R2
    AST_RTS_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |-> (rts_n_pin == !reg_rdata[1])); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin == (irq_req && reg_rdata[3])); // R4
    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata == ($past(reg_wdata) & KEEP_MASK))); // R5
    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(reg_rdata)); // R5
    AST_SER_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] |-> (ser_out_pin && rsr_sin == tsr_sout)); // R6
    AST_SER_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |-> (ser_out_pin == tsr_sout && rsr_sin == ser_in_pin)); // R6
    AST_STATUS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] |-> (st_dsr == reg_rdata[0] && st_cts == reg_rdata[1]
                          && st_ri == reg_rdata[2] && st_dcd == reg_rdata[3])); // R7
    AST_STATUS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |-> (st_cts == !cts_n_pin && st_dsr == !dsr_n_pin
                           && st_dcd == !dcd_n_pin && st_ri == !ri_n_pin)); // R7
    AST_PINS_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] |-> (dtr_n_pin && rts_n_pin)); // R8
    AST_LOOP_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !reg_we) |=> $stable({st_cts, st_dsr, st_dcd, st_ri})); // R10
endmodule

bind modem_ctrl_unit mcr_checker #(.REG_W(REG_W)) i_mcr_checker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_in_pin(ser_in_pin), .ser_out_pin(ser_out_pin),
    .tsr_sout(tsr_sout), .rsr_sin(rsr_sin), .dtr_n_pin(dtr_n_pin),
    .rts_n_pin(rts_n_pin), .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin),
    .dcd_n_pin(dcd_n_pin), .ri_n_pin(ri_n_pin), .st_cts(st_cts),
    .st_dsr(st_dsr), .st_dcd(st_dcd), .st_ri(st_ri), .irq_req(irq_req),
    .irq_pin(irq_pin)
);

// File: tb/test_modem_ctrl_unit.sv
`timescale 1ns/1ps
module test_modem_ctrl_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ser_in_pin = 1'b1;
    logic       ser_out_pin;
    logic       tsr_sout = 1'b1;
    logic       rsr_sin;
    logic       dtr_n_pin, rts_n_pin;
    logic       cts_n_pin = 1'b1, dsr_n_pin = 1'b1, dcd_n_pin = 1'b1, ri_n_pin = 1'b1;
    logic       st_cts, st_dsr, st_dcd, st_ri;
    logic       irq_req = 1'b0;
    logic       irq_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    modem_ctrl_unit i_modem_ctrl_unit (.*);

    // Vector: write value, modem pins {cts_n,dsr_n,dcd_n,ri_n}, tsr, sin, irq_req,
    // expected read data, pins {dtr_n,rts_n,ser_out,irq}, rsr_sin, status {cts,dsr,dcd,ri}
    typedef struct packed {
        logic [7:0] w;
        logic [3:0] mn;
        logic       tsr;
        logic       sin;
        logic       irq;
        logic [7:0] exp_rd;
        logic [3:0] exp_pins;
        logic       exp_rsr;
        logic [3:0] exp_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h03, 4'b0101, 1'b0, 1'b1, 1'b1, 8'h03, 4'b0000, 1'b1, 4'b1010},
        '{8'hE9, 4'b1111, 1'b1, 1'b0, 1'b1, 8'h09, 4'b0111, 1'b0, 4'b0000},
        '{8'h04, 4'b0000, 1'b1, 1'b0, 1'b1, 8'h04, 4'b1110, 1'b0, 4'b1111},
        '{8'h10, 4'b0000, 1'b0, 1'b1, 1'b1, 8'h10, 4'b1110, 1'b0, 4'b0000},
        '{8'h13, 4'b1111, 1'b1, 1'b0, 1'b1, 8'h13, 4'b1110, 1'b1, 4'b1100},
        '{8'h1C, 4'b0101, 1'b0, 1'b1, 1'b1, 8'h1C, 4'b1111, 1'b0, 4'b0011},
        '{8'hFF, 4'b1010, 1'b1, 1'b0, 1'b0, 8'h1F, 4'b1110, 1'b1, 4'b1111},
        '{8'h0B, 4'b0110, 1'b0, 1'b0, 1'b1, 8'h0B, 4'b0001, 1'b0, 4'b1001},
        '{8'h08, 4'b1110, 1'b1, 1'b1, 1'b0, 8'h08, 4'b1110, 1'b1, 4'b0001}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pins_now();
        return {dtr_n_pin, rts_n_pin, ser_out_pin, irq_pin};
    endfunction

    function automatic logic [3:0] st_now();
        return {st_cts, st_dsr, st_dcd, st_ri};
    endfunction

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        #0.5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] snap_pins;
        logic [3:0] snap_st;
        logic       snap_rsr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rdata", reg_rdata, 8'h00);
        chk("R1", "pins", {4'b0, pins_now()}, {4'b0, 4'b1110});

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_we = 1'b1;
            reg_wdata = VEC[i].w;
            {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = VEC[i].mn;
            tsr_sout = VEC[i].tsr;
            ser_in_pin = VEC[i].sin;
            irq_req = VEC[i].irq;
            @(negedge clk);
            reg_we = 1'b0;
            #0.5;
            chk("R5", "rdata", reg_rdata, VEC[i].exp_rd);
            chk(VEC[i].exp_rd[4] ? "R8" : "R2", "dtr_n", {7'b0, dtr_n_pin}, {7'b0, VEC[i].exp_pins[3]});
            chk(VEC[i].exp_rd[4] ? "R8" : "R3", "rts_n", {7'b0, rts_n_pin}, {7'b0, VEC[i].exp_pins[2]});
            chk("R6", "ser_out", {7'b0, ser_out_pin}, {7'b0, VEC[i].exp_pins[1]});
            chk(VEC[i].exp_rd[4] ? "R10" : "R4", "irq", {7'b0, irq_pin}, {7'b0, VEC[i].exp_pins[0]});
            chk("R6", "rsr_sin", {7'b0, rsr_sin}, {7'b0, VEC[i].exp_rsr});
            chk("R7", "status", {4'b0, st_now()}, {4'b0, VEC[i].exp_st});
        end

        // R9: aux bit has no external effect with loopback off
        tsr_sout = 1'b0; ser_in_pin = 1'b1; irq_req = 1'b1;
        {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = 4'b0011;
        write_reg(8'h03);
        snap_pins = pins_now(); snap_st = st_now(); snap_rsr = rsr_sin;
        write_reg(8'h07);
        chk("R9", "rdata", reg_rdata, 8'h07);
        chk("R9", "pins", {4'b0, pins_now()}, {4'b0, snap_pins});
        chk("R9", "status", {4'b0, st_now()}, {4'b0, snap_st});
        chk("R9", "rsr_sin", {7'b0, rsr_sin}, {7'b0, snap_rsr});

        // R5: upper bits ignored, low bits cleared by write
        write_reg(8'hE0);
        chk("R5", "rdata upper", reg_rdata, 8'h00);
        // R5: register holds with no write
        repeat (3) @(negedge clk);
        chk("R5", "hold", reg_rdata, 8'h00);

        // R6: in loopback, serial input pin ignored, transmit path followed
        write_reg(8'h10);
        tsr_sout = 1'b1; ser_in_pin = 1'b0; #0.5;
        chk("R6", "rsr follows tsr", {7'b0, rsr_sin}, 8'h01);
        ser_in_pin = 1'b1; tsr_sout = 1'b0; #0.5;
        chk("R6", "rsr ignores sin", {7'b0, rsr_sin}, 8'h00);
        chk("R6", "ser_out marking", {7'b0, ser_out_pin}, 8'h01);

        // R7/R10: pins toggled in loopback do not move status
        write_reg(8'h15);   // loop, aux, dtr: dsr=1 ri=1
        {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = 4'b0000; #0.5;
        chk("R7", "status pins low", {4'b0, st_now()}, {4'b0, 4'b0101});
        {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = 4'b1111; #0.5;
        chk("R10", "status pins high", {4'b0, st_now()}, {4'b0, 4'b0101});
        // R10: a write changes status and gates irq in loopback
        irq_req = 1'b1;
        write_reg(8'h1A);   // loop, irq_en, rts: cts=1 dcd=1
        chk("R10", "status after write", {4'b0, st_now()}, {4'b0, 4'b1010});
        chk("R10", "irq enabled", {7'b0, irq_pin}, 8'h01);
        chk("R8", "dtr/rts parked", {6'b0, dtr_n_pin, rts_n_pin}, 8'h03);

        // R1: reset in the middle of a run
        write_reg(8'h0B);
        @(negedge clk);
        rst_n = 1'b0; #0.5;
        chk("R1", "mid reset rdata", reg_rdata, 8'h00);
        chk("R1", "mid reset pins", {4'b0, dtr_n_pin, rts_n_pin, 1'b0, irq_pin}, {4'b0, 4'b1100});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule